// File: doc/BRIEF.md
# Dual DAC Register Update Controller

This block is the register front end for a pair of 12-bit digital-to-analog converter channels on an 8-bit special-function-register write bus. It holds a control byte and a high and a low data byte for each channel. From these it decides when each channel's output code is latched, and which code goes to the converter.

The code a channel presents depends on several settings. Both channels share one width setting, either 12-bit or 8-bit. Each channel has its own clear bit and its own power bit. A shared timing bit either loads a channel as soon as its low byte is written, or buffers every data write until a later release loads both channels in the same cycle. The block also passes each channel's range select straight through to the analog side. For each channel that is powered up, it raises a flag that removes the shared input from the ADC multiplexer.

Software writes the high byte first and the low byte second. The low-byte write is the one that loads the channel. To change both outputs in the same cycle, software clears the timing bit, writes all four data bytes, and then writes the control byte with the timing bit set again.

Top module: `dac_pair_regfront`

## Requirements
- R1: After reset the control byte is 0x04 and all data bytes and latched codes are zero, so both codes, `range_rail`, `chan_on` and `adc_in_claimed` read zero.
- R2: The control byte lives at address 0xFD. Its bits, from bit 7 down, are: width select, range 1, range 0, clear 1, clear 0, timing, power 1, power 0. `range_rail[x]` follows control bit 5+x.
- R3: The data bytes are at these addresses: channel 0 low 0xF9, channel 0 high 0xFA, channel 1 low 0xFB, channel 1 high 0xFC. In 12-bit mode (bit 7 = 0) with the timing bit at 1, a low-byte write loads the code {high[3:0], low}. The new code is visible on the cycle after the write. A high-byte write alone does not change the code. High-byte bits 7:4 are ignored.
- R4: In 8-bit mode (bit 7 = 1) with the timing bit at 1, a low-byte write loads the code {low, 4'h0}. The high byte plays no part.
- R5: While the timing bit is 0, data-byte writes change no output code.
- R6: A control write that takes the timing bit from 0 to 1 loads both channels from their stored bytes. It uses the width bit carried in that same write. A control write that leaves the timing bit unchanged loads nothing.
- R7: With clear bit 3+x at 0, channel x presents code zero. When the bit returns to 1, the latched code appears again.
- R8: With power bit x at 0, channel x presents code zero and `chan_on[x]` is low. The stored and latched values are kept and reappear at power-up.
- R9: `adc_in_claimed[0]` (ADC input 4) is high exactly while channel 0 is powered, and `adc_in_claimed[1]` (ADC input 5) exactly while channel 1 is powered.
- R10: A write to any other address, or bus activity with `sfr_we` low, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_we | input | 1 | Write strobe |
| sfr_addr | input | 8 | Write address |
| sfr_wdata | input | 8 | Write data |
| dac0_code | output | 12 | Code presented to converter 0 |
| dac1_code | output | 12 | Code presented to converter 1 |
| range_rail | output | 2 | Per-channel range select (1 = supply rail) |
| chan_on | output | 2 | Per-channel power enable |
| adc_in_claimed | output | 2 | ADC inputs 4 and 5 taken by the DAC pins |

## Verification
Every result is due on the cycle after the write that causes it. Each write goes through one register stage, and the outputs are combinational from those registers. The bench drives each write on a falling edge and removes it on the next falling edge, then compares every output at that point. The rising edge in between has already applied the write, and nothing else can change the outputs before the next write. A bench model, built from the requirements, predicts each value and is updated on the same write. The sweeps cover every low byte in both modes, several high bytes with noise in the ignored nibble, and all 256 control values written in sequence.

// File: rtl/dac_pair_regfront.sv
module dac_pair_regfront #(
  parameter int ADDR_W = 8,
  parameter int BUS_W = 8,
  parameter int CODE_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFD,
  parameter logic [ADDR_W-1:0] LO0_ADDR = 8'hF9,
  parameter logic [ADDR_W-1:0] HI0_ADDR = 8'hFA,
  parameter logic [ADDR_W-1:0] LO1_ADDR = 8'hFB,
  parameter logic [ADDR_W-1:0] HI1_ADDR = 8'hFC,
  parameter logic [BUS_W-1:0] CTRL_RESET = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [BUS_W-1:0]  sfr_wdata,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [1:0]        range_rail,
  output logic [1:0]        chan_on,
  output logic [1:0]        adc_in_claimed
);
  localparam int HI_W = CODE_W - BUS_W;
  localparam int B_WIDTH = 7, B_RNG = 5, B_CLR = 3, B_SYNC = 2, B_PWR = 0;

  logic [BUS_W-1:0] ctrl_q;
  logic             ctrl_wr, sync_release;
  logic [CODE_W-1:0] shown [2];

  function automatic logic [CODE_W-1:0] pack_code(input logic narrow,
      input logic [HI_W-1:0] hi, input logic [BUS_W-1:0] lo);
    pack_code = narrow ? {lo, {HI_W{1'b0}}} : {hi, lo};
  endfunction

  assign ctrl_wr = sfr_we && (sfr_addr == CTRL_ADDR);
  assign sync_release = ctrl_wr && !ctrl_q[B_SYNC] && sfr_wdata[B_SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else if (ctrl_wr) ctrl_q <= sfr_wdata;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = (ch == 0) ? LO0_ADDR : LO1_ADDR;
    localparam logic [ADDR_W-1:0] HI_A = (ch == 0) ? HI0_ADDR : HI1_ADDR;
    logic [BUS_W-1:0]  lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [CODE_W-1:0] held_q;
    logic lo_wr, hi_wr;

    assign lo_wr = sfr_we && (sfr_addr == LO_A);
    assign hi_wr = sfr_we && (sfr_addr == HI_A);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        held_q <= '0;
      end else begin
        if (lo_wr) lo_q <= sfr_wdata;
        if (hi_wr) hi_q <= sfr_wdata[HI_W-1:0];
        if (lo_wr && ctrl_q[B_SYNC])
          held_q <= pack_code(ctrl_q[B_WIDTH], hi_q, sfr_wdata);
        else if (sync_release)
          held_q <= pack_code(sfr_wdata[B_WIDTH], hi_q, lo_q);
      end
    end

    assign shown[ch] = (ctrl_q[B_PWR+ch] && ctrl_q[B_CLR+ch]) ? held_q : '0;
    assign range_rail[ch] = ctrl_q[B_RNG+ch];
    assign chan_on[ch] = ctrl_q[B_PWR+ch];
    assign adc_in_claimed[ch] = ctrl_q[B_PWR+ch];
  end

  assign dac0_code = shown[0];
  assign dac1_code = shown[1];
endmodule

// File: rtl/dac_pair_regfront_chk.sv
module dac_pair_regfront_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W = 8,
  parameter int CODE_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFD,
  parameter logic [ADDR_W-1:0] LO0_ADDR = 8'hF9,
  parameter logic [ADDR_W-1:0] LO1_ADDR = 8'hFB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [BUS_W-1:0]  ctrl_q,
  input logic [CODE_W-1:0] dac0_code,
  input logic [CODE_W-1:0] dac1_code,
  input logic [1:0]        chan_on,
  input logic [1:0]        adc_in_claimed
);
  assert_off_zero0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on[0] |-> dac0_code == '0);
  assert_off_zero1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on[1] |-> dac1_code == '0);
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sfr_we) |-> ($stable(dac0_code) && $stable(dac1_code)));
  assert_claim_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_in_claimed[0]) |-> $past(sfr_we && sfr_addr == CTRL_ADDR));
  assert_narrow_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfr_we && sfr_addr == LO0_ADDR && ctrl_q[7] && ctrl_q[2]) |-> dac0_code[3:0] == 4'h0);
  assert_buffered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfr_we && sfr_addr == LO1_ADDR && !ctrl_q[2]) |-> $stable(dac1_code));
endmodule

bind dac_pair_regfront dac_pair_regfront_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CODE_W(CODE_W),
  .CTRL_ADDR(CTRL_ADDR), .LO0_ADDR(LO0_ADDR), .LO1_ADDR(LO1_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .ctrl_q(ctrl_q), .dac0_code(dac0_code), .dac1_code(dac1_code),
  .chan_on(chan_on), .adc_in_claimed(adc_in_claimed)
);

// File: tb/dac_pair_regfront_test.sv
module dac_pair_regfront_test;
  logic clk = 0, rst_n = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [11:0] code0, code1;
  logic [1:0] rng, on, claimed;
  int checks = 0, fails = 0;

  logic [7:0] m_ctrl;
  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  logic [11:0] m_held [2];

  always #5 clk = ~clk;

  dac_pair_regfront uut (
    .clk(clk), .rst_n(rst_n), .sfr_we(we), .sfr_addr(addr), .sfr_wdata(wdata),
    .dac0_code(code0), .dac1_code(code1), .range_rail(rng),
    .chan_on(on), .adc_in_claimed(claimed));

  function automatic logic [11:0] form(input logic narrow, input logic [3:0] h, input logic [7:0] l);
    return narrow ? {l, 4'h0} : {h, l};
  endfunction

  function automatic logic [11:0] expect_code(input int ch);
    return (m_ctrl[ch] && m_ctrl[3+ch]) ? m_held[ch] : 12'h0;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp({req, " code0"}, 32'(code0), 32'(expect_code(0)));
    cmp({req, " code1"}, 32'(code1), 32'(expect_code(1)));
    cmp({req, " range(R2)"}, 32'(rng), 32'({m_ctrl[6], m_ctrl[5]}));
    cmp({req, " on(R8)"}, 32'(on), 32'({m_ctrl[1], m_ctrl[0]}));
    cmp({req, " claim(R9)"}, 32'(claimed), 32'({m_ctrl[1], m_ctrl[0]}));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic strobe = 1'b1);
    @(negedge clk);
    we = strobe; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
    if (strobe) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (a == (ch == 0 ? 8'hF9 : 8'hFB)) begin
          if (m_ctrl[2]) m_held[ch] = form(m_ctrl[7], m_hi[ch], d);
          m_lo[ch] = d;
        end
        if (a == (ch == 0 ? 8'hFA : 8'hFC)) m_hi[ch] = d[3:0];
      end
      if (a == 8'hFD) begin
        if (!m_ctrl[2] && d[2])
          for (int ch = 0; ch < 2; ch++) m_held[ch] = form(d[7], m_hi[ch], m_lo[ch]);
        m_ctrl = d;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] hipat [4];
    hipat[0] = 8'h00; hipat[1] = 8'hA5; hipat[2] = 8'h3A; hipat[3] = 8'hFF;
    m_ctrl = 8'h04;
    for (int ch = 0; ch < 2; ch++) begin m_lo[ch] = 0; m_hi[ch] = 0; m_held[ch] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    wr(8'hFD, 8'h1F);
    check_all("R2 control write");
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 256; l++) begin
        wr(8'hFA, hipat[h]); check_all("R3 high only ch0");
        wr(8'hF9, 8'(l));    check_all("R3 12-bit ch0");
        wr(8'hFC, ~hipat[h]); check_all("R3 high only ch1");
        wr(8'hFB, 8'(255 - l)); check_all("R3 12-bit ch1");
      end

    wr(8'hFD, 8'h9F);
    for (int l = 0; l < 256; l++) begin
      wr(8'hFA, 8'(l)); wr(8'hF9, 8'(l)); check_all("R4 8-bit ch0");
      wr(8'hFC, 8'(~l)); wr(8'hFB, 8'(l ^ 8'h5A)); check_all("R4 8-bit ch1");
    end

    for (int p = 0; p < 16; p++) begin
      logic narrow = p[0];
      wr(8'hFD, {narrow, 7'h1B}); check_all("R5 enter buffered");
      wr(8'hFA, 8'(p * 17)); wr(8'hF9, 8'(p * 13 + 1)); check_all("R5 buffered ch0");
      wr(8'hFC, 8'(p * 7));  wr(8'hFB, 8'(p * 29 + 3)); check_all("R5 buffered ch1");
      wr(8'hFD, {narrow, 7'h1B}); check_all("R6 timing 0->0 no load");
      wr(8'hFD, {~narrow, 7'h1F}); check_all("R6 release both");
      wr(8'hFD, {narrow, 7'h1F}); check_all("R6 timing 1->1 no load");
    end

    wr(8'hFD, 8'h1F); wr(8'hFA, 8'h07); wr(8'hF9, 8'hC3); wr(8'hFC, 8'h02); wr(8'hFB, 8'h81);
    wr(8'hFD, 8'h17); check_all("R7 clear ch0");
    wr(8'hFD, 8'h0F); check_all("R7 clear ch1");
    wr(8'hFD, 8'h1F); check_all("R7 restored");
    wr(8'hFD, 8'h1D); check_all("R8 power down ch1");
    wr(8'hFD, 8'h1C); check_all("R8 power down both");
    wr(8'hFD, 8'h1F); check_all("R8 power restored");
    wr(8'hFD, 8'h19); check_all("R9 ch0 only on");

    wr(8'hFD, 8'h1F);
    for (int a = 0; a < 256; a++)
      if (a < 8'hF9 || a > 8'hFD) begin
        wr(8'(a), 8'(a ^ 8'h3C)); check_all("R10 other address");
      end
    wr(8'hF9, 8'h11, 1'b0); check_all("R10 strobe low");
    wr(8'hFD, 8'h00, 1'b0); check_all("R10 strobe low ctrl");

    for (int c = 0; c < 256; c++) begin
      wr(8'hFD, 8'(c)); check_all("R2 control sweep");
      wr(8'hF9, 8'(c * 3)); check_all("R2 sweep data ch0");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule